// File: doc/BRIEF.md
# Level-Match Interrupt GPIO Controller

This block manages a bank of general-purpose pins through six 32-bit word registers on a simple request/response bus. For each pin, software picks one of two owners: the GPIO logic or an alternate-function peripheral. A GPIO pin has a direction bit and a data bit. Each pin is also compared against a programmable level. When the synchronised pin value equals that level, a sticky flag for the pin is set. A per-pin enable mask routes the flags onto a single non-maskable interrupt output.

Bus reads are handled by a two-state access machine. In `BUS_IDLE` no response is pending. A read request moves the machine to `BUS_RESP` (transition *read-accept*), and in that state the read data is presented with a valid strobe. From `BUS_RESP`, another read keeps the machine in `BUS_RESP` (transition *read-chain*). Anything else returns it to `BUS_IDLE` (transition *response-done*). A write never leaves `BUS_IDLE` (transition *write-stay*).

Top module: `gpio_lvlirq_ctrl`

## Requirements
- R1: After reset, every pin is a GPIO input. `pad_oe` and `pad_out` are zero, `nmi_o` is low, and the function, direction, output data, level and interrupt-enable registers read zero.
- R2: The register byte offsets are as follows: function select 0x00, direction 0x04, pin data 0x08, match level 0x0C, flags 0x10, interrupt enable 0x14. Every other address reads zero.
- R3: A function-select bit of 1 drives that pin's `pad_out`/`pad_oe` from `alt_out`/`alt_oe`. A bit of 0 gives the pin to the GPIO logic.
- R4: For a GPIO pin, a direction bit of 1 asserts `pad_oe` and a bit of 0 releases it.
- R5: Writing the data register sets the GPIO output value on `pad_out`. Reading the data register returns the pad input after a two-flop synchroniser.
- R6: A flag bit is set when the synchronised pin equals its level bit. A level of 1 matches a high pin and a level of 0 matches a low pin.
- R7: A flag bit stays set after the pin stops matching.
- R8: Writing 0 to a flag bit clears it and writing 1 keeps it. A match present in the cycle of the clear keeps the bit set.
- R9: `nmi_o` is high exactly when some flag bit and its enable bit are both 1.
- R10: A pin in alternate-function mode still shows its level in the data register and still sets its flag.
- R11: A read request yields `bus_rvalid` high with data in the following cycle. A write yields no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| alt_out | input | 32 | Alternate-function output values |
| alt_oe | input | 32 | Alternate-function output enables |
| alt_in | output | 32 | Pad levels passed to alternate functions |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
Flag capture is tried with high-level matches on a sparse pin pattern and with low-level matches on a whole byte. This separates correct polarity handling from a comparator that only detects ones. The clear path is tried in three ways: a selective clear, a full clear while no match is present, and a full clear while a match persists. Together these separate write-zero-to-clear, keep-on-one and match-over-clear priority. Direction and data are tried with split half-word patterns, using a loopback pad model, so that output and input pins read back differently. The alternate-function case checks that a pin owned by a peripheral stops driving from the GPIO side but still reports its level and raises its flag.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
    localparam int NREG = 6;
    localparam int IDX_SEL   = 0;
    localparam int IDX_DIR   = 1;
    localparam int IDX_DATA  = 2;
    localparam int IDX_LVL   = 3;
    localparam int IDX_FLAG  = 4;
    localparam int IDX_NMIEN = 5;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_lvl_pkg::*;
#(
    parameter int NPIN = 32,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [NPIN-1:0] pin_val,
    input  logic [NPIN-1:0] match,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_rdata,
    output logic [NPIN-1:0] sel_q,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] dout_q,
    output logic [NPIN-1:0] lvl_q,
    output logic [NPIN-1:0] flag_q,
    output logic [NPIN-1:0] nmien_q
);
    logic [NREG-1:0] hit;
    logic [DW-1:0]   rd_mux;
    logic            rd_req;
    logic            wr_req;
    bus_state_e      state_q, state_d;

    for (genvar r = 0; r < NREG; r++) begin : g_dec
        assign hit[r] = (addr == AW'(r * 4));
    end

    assign rd_req = req && !we;
    assign wr_req = req && we;

    // Control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            dir_q   <= '0;
            dout_q  <= '0;
            lvl_q   <= '0;
            nmien_q <= '0;
        end else if (wr_req) begin
            if (hit[IDX_SEL])   sel_q   <= wdata[NPIN-1:0];
            if (hit[IDX_DIR])   dir_q   <= wdata[NPIN-1:0];
            if (hit[IDX_DATA])  dout_q  <= wdata[NPIN-1:0];
            if (hit[IDX_LVL])   lvl_q   <= wdata[NPIN-1:0];
            if (hit[IDX_NMIEN]) nmien_q <= wdata[NPIN-1:0];
        end
    end

    // Sticky flags: write-0 clears, a live match wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= '0;
        else if (wr_req && hit[IDX_FLAG])
            flag_q <= (flag_q & wdata[NPIN-1:0]) | match;
        else
            flag_q <= flag_q | match;
    end

    always_comb begin
        rd_mux = '0;
        if (hit[IDX_SEL])   rd_mux = DW'(sel_q);
        if (hit[IDX_DIR])   rd_mux = DW'(dir_q);
        if (hit[IDX_DATA])  rd_mux = DW'(pin_val);
        if (hit[IDX_LVL])   rd_mux = DW'(lvl_q);
        if (hit[IDX_FLAG])  rd_mux = DW'(flag_q);
        if (hit[IDX_NMIEN]) rd_mux = DW'(nmien_q);
    end

    // Bus access machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_req) state_d = BUS_RESP;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // Bus access machine: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (rd_req) rsp_rdata <= rd_mux;
    end

    assign rsp_valid = (state_q == BUS_RESP);

    p_read_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    p_write_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !rsp_valid);
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && hit[IDX_FLAG]) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
    p_match_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(match)) == $past(match)));
endmodule

// File: rtl/gpio_lvlirq_ctrl.sv
module gpio_lvlirq_ctrl #(
    parameter int NPIN        = 32,
    parameter int AW          = 8,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic            bus_rvalid,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    input  logic [NPIN-1:0] alt_out,
    input  logic [NPIN-1:0] alt_oe,
    output logic [NPIN-1:0] alt_in,
    output logic            nmi_o
);
    logic [NPIN-1:0] pin_sync;
    logic [NPIN-1:0] match;
    logic [NPIN-1:0] sel_q, dir_q, dout_q, lvl_q, flag_q, nmien_q;

    gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    assign match = ~(pin_sync ^ lvl_q);

    gpio_regfile #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bus_req),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .pin_val   (pin_sync),
        .match     (match),
        .rsp_valid (bus_rvalid),
        .rsp_rdata (bus_rdata),
        .sel_q     (sel_q),
        .dir_q     (dir_q),
        .dout_q    (dout_q),
        .lvl_q     (lvl_q),
        .flag_q    (flag_q),
        .nmien_q   (nmien_q)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pad
        assign pad_out[i] = sel_q[i] ? alt_out[i] : dout_q[i];
        assign pad_oe[i]  = sel_q[i] ? alt_oe[i]  : dir_q[i];
    end

    assign alt_in = pad_in;
    assign nmi_o  = |(flag_q & nmien_q);

    p_nmi_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nmien_q == '0) |-> !nmi_o);
    p_gpio_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_q == '0) && (dir_q == '0)) |-> (pad_oe == '0));
endmodule

// File: tb/gpio_lvlirq_ctrl_tb_top.sv
module gpio_lvlirq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in, pad_out, pad_oe, alt_in;
    logic [31:0] alt_out = '0;
    logic [31:0] alt_oe = '0;
    logic [31:0] ext = '0;
    logic        nmi_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    // loopback pad model
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_lvlirq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .nmi_o(nmi_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    // monitor: pop and compare read responses
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R11: unexpected response actual %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 nmi", {31'h0, nmi_o}, 32'h0);
        rd(8'h00, 32'h0, "R1 sel");
        rd(8'h04, 32'h0, "R1 dir");
        rd(8'h0C, 32'h0, "R1 lvl");
        rd(8'h14, 32'h0, "R1 nmien");
        rd(8'h08, 32'h0, "R1 data");

        // R2 register map
        wr(8'h00, 32'h1357_9BDF); rd(8'h00, 32'h1357_9BDF, "R2 sel@00");
        wr(8'h00, 32'h0);
        wr(8'h0C, 32'hDEAD_BEEF); rd(8'h0C, 32'hDEAD_BEEF, "R2 lvl@0C");
        wr(8'h14, 32'h0F0F_0F0F); rd(8'h14, 32'h0F0F_0F0F, "R2 nmien@14");
        wr(8'h14, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, 32'h0, "R2 unused 18");
        rd(8'h05, 32'h0, "R2 unaligned 05");
        check("R11 no response after write", {31'h0, bus_rvalid}, 32'h0);

        // R4 / R5 direction and data
        wr(8'h04, 32'h0000_FFFF);
        wr(8'h08, 32'hA5A5_3C3C);
        check("R4 pad_oe", pad_oe, 32'h0000_FFFF);
        check("R5 pad_out", pad_out, 32'hA5A5_3C3C);
        ext = 32'h1234_0000;
        wait_cyc(3);
        rd(8'h08, 32'h1234_3C3C, "R5 data read");
        rd(8'h04, 32'h0000_FFFF, "R2 dir@04");

        // R3 function select
        alt_out = 32'hC300_0000; alt_oe = 32'h0F00_0000;
        wr(8'h00, 32'hFF00_0000);
        check("R3 pad_out alt", pad_out, 32'hC3A5_3C3C);
        check("R3 pad_oe alt", pad_oe, 32'h0F00_FFFF);
        wr(8'h00, 32'h0); wr(8'h04, 32'h0); wr(8'h08, 32'h0);
        alt_out = '0; alt_oe = '0;
        ext = '0;
        wait_cyc(4);

        // R6 / R7 / R8 flags
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h10, 32'h0);
        rd(8'h10, 32'h0, "R8 full clear");
        ext = 32'h0000_0011;
        wait_cyc(4);
        rd(8'h10, 32'h0000_0011, "R6 high match");
        ext = '0;
        wait_cyc(4);
        rd(8'h10, 32'h0000_0011, "R7 sticky");
        wr(8'h10, 32'hFFFF_FFEF);
        rd(8'h10, 32'h0000_0001, "R8 selective clear");
        wr(8'h0C, 32'hFFFF_FF00);
        wait_cyc(2);
        rd(8'h10, 32'h0000_00FF, "R6 low match");
        wr(8'h10, 32'h0);
        rd(8'h10, 32'h0000_00FF, "R8 match wins");
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h10, 32'h0);
        rd(8'h10, 32'h0, "R8 clear after");

        // R9 interrupt output
        ext = 32'h0000_0020;
        wait_cyc(4);
        check("R9 masked", {31'h0, nmi_o}, 32'h0);
        wr(8'h14, 32'h0000_0020);
        check("R9 enabled", {31'h0, nmi_o}, 32'h1);
        wr(8'h14, 32'h0000_0040);
        check("R9 other enable", {31'h0, nmi_o}, 32'h0);
        wr(8'h14, 32'h0000_0020);
        wr(8'h10, 32'h0);
        check("R9 R8 clear during match", {31'h0, nmi_o}, 32'h1);
        ext = '0;
        wait_cyc(4);
        wr(8'h10, 32'h0);
        check("R9 cleared", {31'h0, nmi_o}, 32'h0);
        wr(8'h14, 32'h0);

        // R10 alternate-function pin
        wr(8'h00, 32'h0000_0100);
        wr(8'h04, 32'h0000_0100);
        check("R3 alt owns oe", pad_oe, 32'h0);
        ext = 32'h0000_0100;
        wait_cyc(4);
        check("R10 alt_in", alt_in, 32'h0000_0100);
        rd(8'h08, 32'h0000_0100, "R10 data read");
        rd(8'h10, 32'h0000_0100, "R10 flag");

        wait_cyc(2);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11: missing responses actual %0d expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule